// File: doc/BRIEF.md
# Empty/Full Tagged Message Cell

This block is a single message-passing storage cell shared by several hardware threads. It holds a small circular buffer of data words together with a tag: an empty flag, a full flag, a trap flag and an occupancy count. A requester issues one access per cycle and selects one of four views. The raw view peeks at or patches the buffer without moving it. The tag view reads or loads the tag word. The waiting view and the trying view both enqueue on a write and dequeue on a read.

An access through the waiting view that cannot proceed does not complete. A dequeue cannot proceed while the empty flag is set, and an enqueue cannot proceed while the full flag is set. Such an access raises `rsp_stall` in the same cycle and records the requester's thread number in a blocked-thread mask. The next enqueue or dequeue that does proceed produces a one-cycle wake pulse one clock later. That pulse carries the recorded mask, and the mask is then emptied. Responses are combinational in the cycle of the request. Tag and buffer updates take effect at the next rising edge.

Top module: `msg_cell`

## Requirements
- R1: After reset, a tag-view read returns empty=1, full=0, trap=0, occupancy 0, the mode bit set and the depth code log2(DEPTH).
- R2: The tag word places empty at bit 0, full at bit 1, trap at bit 16, the mode bit (always 1) at bit 17, the occupancy count from bit 18, and the depth code from bit 28. All other bits read 0.
- R3: A tag-view write loads trap, empty and full from write-data bits 16, 0 and 1. When the loaded empty bit is 1, the occupancy count becomes 0.
- R4: A dequeue that proceeds clears full. If the occupancy is non-zero, it returns the oldest entry, advances the head and decrements the count. Empty is set when the count ends at 0.
- R5: A trying-view dequeue on a cell with occupancy 0 returns 0, never stalls, sets empty and clears full.
- R6: An enqueue that proceeds clears empty. If the count is below DEPTH, it stores the data behind the newest entry and increments the count. Full is set when the count equals DEPTH. The count never exceeds DEPTH.
- R7: A trying-view enqueue with occupancy equal to DEPTH leaves the stored entries and the count unchanged.
- R8: A waiting-view dequeue while empty is set asserts `rsp_stall`, clears full, returns nothing, does not move the buffer and adds the requester to the blocked mask.
- R9: A waiting-view enqueue while full is set asserts `rsp_stall`, clears empty, stores nothing and adds the requester to the blocked mask. Only the waiting view ever stalls.
- R10: An enqueue or dequeue that proceeds while the blocked mask is non-zero raises `wake_valid` for exactly the following cycle, with `wake_mask` equal to that mask. The mask is then empty. `wake_valid` is low at all other times.
- R11: A raw-view read returns the entry at the head without changing the occupancy or the head.
- R12: A raw-view write overwrites the newest entry when the occupancy is non-zero. It has no effect when the occupancy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_view | input | 2 | 0 raw, 1 tag, 2 waiting queue, 3 trying queue |
| req_write | input | 1 | 1 write/enqueue, 0 read/dequeue |
| req_tid | input | $clog2(THREADS) | Requesting thread number |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, valid in the request cycle |
| rsp_stall | output | 1 | Waiting-view access could not proceed |
| wake_valid | output | 1 | One-cycle wake pulse |
| wake_mask | output | THREADS | Threads to wake, zero when no pulse |

## Verification
The assertions take for granted that `rst_n` starts low and that no access is presented during reset. They also assume that a stalled requester does not re-issue in the same cycle as a proceeding access, since only one request port exists. The stimulus drives exactly one access per cycle on the falling edge. It draws views, thread numbers and data from a seeded generator, weighted so that runs of enqueues and dequeues reach the full and empty boundaries often. Tag-view writes are kept rare so that the flags mostly follow the occupancy, yet the flags still get driven out of step with it at times.

// File: rtl/msg_cell_pkg.sv
package msg_cell_pkg;

    typedef enum logic [1:0] {
        VIEW_RAW  = 2'd0,
        VIEW_TAG  = 2'd1,
        VIEW_WAIT = 2'd2,
        VIEW_TRY  = 2'd3
    } view_e;

    localparam int BIT_EMPTY = 0;
    localparam int BIT_FULL  = 1;
    localparam int BIT_TRAP  = 16;
    localparam int BIT_MODE  = 17;
    localparam int BIT_OCC   = 18;
    localparam int BIT_CODE  = 28;
    localparam int CODE_W    = 4;

endpackage

// File: rtl/msg_cell_store.sv
module msg_cell_store #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DATA_W-1:0] slot_d;
        always_comb begin
            slot_d = slot_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) slot_d = wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d;
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/msg_cell_ctrl.sv
module msg_cell_ctrl
    import msg_cell_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  view_e             req_view,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] st_rdata,
    output logic              st_we,
    output logic [IDX_W-1:0]  st_widx,
    output logic [IDX_W-1:0]  st_ridx,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_stall,
    output logic              q_progress
);

    typedef struct packed {
        logic             e;
        logic             f;
        logic             t;
        logic [PTR_W-1:0] ptr;
        logic [IDX_W-1:0] head;
    } tag_t;

    tag_t s_q, s_d;

    logic [IDX_W-1:0]  tail_idx;
    logic [IDX_W-1:0]  newest_idx;
    logic [DATA_W-1:0] tag_word;
    logic              blocking;

    assign tail_idx   = s_q.head + s_q.ptr[IDX_W-1:0];
    assign newest_idx = tail_idx - IDX_W'(1);
    assign st_ridx    = s_q.head;
    assign blocking   = (req_view == VIEW_WAIT);

    always_comb begin
        tag_word                            = '0;
        tag_word[BIT_EMPTY]                 = s_q.e;
        tag_word[BIT_FULL]                  = s_q.f;
        tag_word[BIT_TRAP]                  = s_q.t;
        tag_word[BIT_MODE]                  = 1'b1;
        tag_word[BIT_OCC +: PTR_W]          = s_q.ptr;
        tag_word[BIT_CODE +: CODE_W]        = CODE_W'(IDX_W);
    end

    always_comb begin
        s_d        = s_q;
        st_we      = 1'b0;
        st_widx    = tail_idx;
        rsp_rdata  = '0;
        rsp_stall  = 1'b0;
        q_progress = 1'b0;
        if (req_valid) begin
            unique case (req_view)
                VIEW_RAW: begin
                    if (req_write) begin
                        if (s_q.ptr != '0) begin
                            st_we   = 1'b1;
                            st_widx = newest_idx;
                        end
                    end else begin
                        rsp_rdata = st_rdata;
                    end
                end
                VIEW_TAG: begin
                    if (req_write) begin
                        s_d.t = req_wdata[BIT_TRAP];
                        s_d.e = req_wdata[BIT_EMPTY];
                        s_d.f = req_wdata[BIT_FULL];
                        if (req_wdata[BIT_EMPTY]) s_d.ptr = '0;
                    end else begin
                        rsp_rdata = tag_word;
                    end
                end
                default: begin
                    if (!req_write) begin
                        s_d.f = 1'b0;
                        if (blocking && s_q.e) begin
                            rsp_stall = 1'b1;
                        end else begin
                            q_progress = 1'b1;
                            if (s_q.ptr != '0) begin
                                rsp_rdata = st_rdata;
                                s_d.head  = s_q.head + IDX_W'(1);
                                s_d.ptr   = s_q.ptr - PTR_W'(1);
                            end
                            if (s_d.ptr == '0) s_d.e = 1'b1;
                        end
                    end else begin
                        s_d.e = 1'b0;
                        if (blocking && s_q.f) begin
                            rsp_stall = 1'b1;
                        end else begin
                            q_progress = 1'b1;
                            if (s_q.ptr < PTR_W'(DEPTH)) begin
                                st_we   = 1'b1;
                                s_d.ptr = s_q.ptr + PTR_W'(1);
                            end
                            if (s_d.ptr == PTR_W'(DEPTH)) s_d.f = 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.e    <= 1'b1;
        end else begin
            s_q      <= s_d;
        end
    end

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ptr <= PTR_W'(DEPTH)); // R6

    AST_LAST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (req_view == VIEW_WAIT || req_view == VIEW_TRY)
         && !rsp_stall && s_q.ptr == PTR_W'(1)) |=> (s_q.e && s_q.ptr == '0)); // R4

    AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall |=> ($stable(s_q.ptr) && $stable(s_q.head))); // R8

    AST_STALL_WAIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall |-> (req_valid && req_view == VIEW_WAIT)); // R9

endmodule

// File: rtl/msg_cell_waker.sv
module msg_cell_waker #(
    parameter int THREADS = 8,
    localparam int TID_W  = $clog2(THREADS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall,
    input  logic               progress,
    input  logic [TID_W-1:0]   tid,
    output logic               wake_valid,
    output logic [THREADS-1:0] wake_mask
);

    typedef struct packed {
        logic [THREADS-1:0] blocked;
        logic               wake;
        logic [THREADS-1:0] wmask;
    } wk_t;

    wk_t w_q, w_d;

    always_comb begin
        w_d       = w_q;
        w_d.wake  = 1'b0;
        w_d.wmask = '0;
        if (stall) begin
            w_d.blocked = w_q.blocked | (THREADS'(1) << tid);
        end else if (progress && (w_q.blocked != '0)) begin
            w_d.wake    = 1'b1;
            w_d.wmask   = w_q.blocked;
            w_d.blocked = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign wake_valid = w_q.wake;
    assign wake_mask  = w_q.wmask;

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |=> !wake_valid); // R10

    AST_WAKE_HAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> (wake_mask != '0)); // R10

    AST_STALL_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (w_q.blocked != '0)); // R8

endmodule

// File: rtl/msg_cell.sv
module msg_cell
    import msg_cell_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int DATA_W  = 64,
    parameter int THREADS = 8,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int TID_W  = $clog2(THREADS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_view,
    input  logic               req_write,
    input  logic [TID_W-1:0]   req_tid,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_stall,
    output logic               wake_valid,
    output logic [THREADS-1:0] wake_mask
);

    logic              st_we;
    logic [IDX_W-1:0]  st_widx;
    logic [IDX_W-1:0]  st_ridx;
    logic [DATA_W-1:0] st_rdata;
    logic              q_progress;

    msg_cell_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_we),
        .wr_idx  (st_widx),
        .wr_data (req_wdata),
        .rd_idx  (st_ridx),
        .rd_data (st_rdata)
    );

    msg_cell_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_view   (view_e'(req_view)),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .st_rdata   (st_rdata),
        .st_we      (st_we),
        .st_widx    (st_widx),
        .st_ridx    (st_ridx),
        .rsp_rdata  (rsp_rdata),
        .rsp_stall  (rsp_stall),
        .q_progress (q_progress)
    );

    msg_cell_waker #(.THREADS(THREADS)) u_waker (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall      (rsp_stall),
        .progress   (q_progress),
        .tid        (req_tid),
        .wake_valid (wake_valid),
        .wake_mask  (wake_mask)
    );

endmodule

// File: tb/msg_cell_tb.sv
`timescale 1ns/1ps
module msg_cell_tb;

    localparam int DEPTH   = 4;
    localparam int DATA_W  = 64;
    localparam int THREADS = 8;
    localparam int TID_W   = $clog2(THREADS);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic [1:0]         req_view = '0;
    logic               req_write = 1'b0;
    logic [TID_W-1:0]   req_tid = '0;
    logic [DATA_W-1:0]  req_wdata = '0;
    logic [DATA_W-1:0]  rsp_rdata;
    logic               rsp_stall;
    logic               wake_valid;
    logic [THREADS-1:0] wake_mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    msg_cell #(.DEPTH(DEPTH), .DATA_W(DATA_W), .THREADS(THREADS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_view(req_view),
        .req_write(req_write), .req_tid(req_tid), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_stall(rsp_stall),
        .wake_valid(wake_valid), .wake_mask(wake_mask)
    );

    // reference model
    logic [DATA_W-1:0]  m_data [DEPTH];
    int                 m_head, m_ptr;
    bit                 m_e, m_f, m_t;
    logic [THREADS-1:0] m_mask;

    function automatic logic [DATA_W-1:0] tag_word();
        logic [DATA_W-1:0] w = '0;
        w[0] = m_e;
        w[1] = m_f;
        w[16] = m_t;
        w[17] = 1'b1;
        w = w | (DATA_W'(m_ptr) << 18) | (DATA_W'($clog2(DEPTH)) << 28);
        return w;
    endfunction

    task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_data[i] = '0;
        m_head = 0; m_ptr = 0; m_e = 1; m_f = 0; m_t = 0; m_mask = '0;
    endtask

    // one access: drive on falling edge, check response, clock, check wake
    task automatic do_op(int view, bit wr, int tid, logic [DATA_W-1:0] wd);
        logic [DATA_W-1:0] exp_rd = '0;
        bit exp_stall = 0, prog = 0, exp_wake = 0;
        logic [THREADS-1:0] exp_wmask = '0;
        string req = "R11";
        @(negedge clk);
        req_valid = 1; req_view = 2'(view); req_write = wr;
        req_tid = TID_W'(tid); req_wdata = wd;
        case (view)
            0: if (wr) begin
                   req = "R12";
                   if (m_ptr != 0) m_data[(m_head + m_ptr - 1) % DEPTH] = wd;
               end else begin
                   req = "R11"; exp_rd = m_data[m_head];
               end
            1: if (wr) begin
                   req = "R3";
                   m_t = wd[16]; m_e = wd[0]; m_f = wd[1];
                   if (wd[0]) m_ptr = 0;
               end else begin
                   req = "R2"; exp_rd = tag_word();
               end
            default: if (!wr) begin
                   req = "R4";
                   m_f = 0;
                   if (view == 2 && m_e) begin
                       req = "R8"; exp_stall = 1;
                   end else begin
                       prog = 1;
                       if (m_ptr == 0) req = "R5";
                       if (m_ptr > 0) begin
                           exp_rd = m_data[m_head];
                           m_head = (m_head + 1) % DEPTH; m_ptr--;
                       end
                       if (m_ptr == 0) m_e = 1;
                   end
               end else begin
                   req = "R6";
                   m_e = 0;
                   if (view == 2 && m_f) begin
                       req = "R9"; exp_stall = 1;
                   end else begin
                       prog = 1;
                       if (m_ptr == DEPTH) req = "R7";
                       if (m_ptr < DEPTH) begin
                           m_data[(m_head + m_ptr) % DEPTH] = wd; m_ptr++;
                       end
                       if (m_ptr == DEPTH) m_f = 1;
                   end
               end
        endcase
        if (exp_stall) m_mask |= THREADS'(1) << tid;
        else if (prog && m_mask != 0) begin
            exp_wake = 1; exp_wmask = m_mask; m_mask = '0;
        end
        #1;
        check(req, DATA_W'(rsp_stall), DATA_W'(exp_stall));
        if (!wr) check(req, rsp_rdata, exp_rd);
        @(posedge clk);
        #1;
        req_valid = 0;
        check("R10", DATA_W'(wake_valid), DATA_W'(exp_wake));
        check("R10", DATA_W'(wake_mask), DATA_W'(exp_wmask));
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset tag word
        @(negedge clk);
        req_valid = 1; req_view = 2'd1; req_write = 0;
        #1;
        check("R1", rsp_rdata, 64'h0000_0000_2002_0001);
        @(posedge clk); #1; req_valid = 0;

        // R6 fill, R7 drop when full, R2 tag shows full
        for (int i = 0; i < DEPTH; i++) do_op(3, 1, 0, 64'hA0 + 64'(i));
        do_op(3, 1, 0, 64'hDEAD);
        do_op(1, 0, 0, '0);
        do_op(0, 0, 0, '0);                 // R11 head peek
        do_op(2, 1, 3, 64'hBEEF);           // R9 stall, thread 3
        do_op(3, 0, 1, '0);                 // R4 pop, R10 wake thread 3
        do_op(0, 1, 0, 64'h5555);           // R12 overwrite newest
        for (int i = 0; i < DEPTH; i++) do_op(3, 0, 0, '0);
        do_op(2, 0, 5, '0);                 // R8 stall, thread 5
        do_op(2, 0, 6, '0);                 // R8 stall, thread 6
        do_op(3, 1, 2, 64'h77);             // R10 wake threads 5,6
        do_op(1, 1, 0, 64'h0001_0001);      // R3 empty+trap clears occupancy
        do_op(1, 0, 0, '0);
        do_op(3, 0, 0, '0);                 // R5 empty try returns 0
        do_op(0, 1, 0, 64'h9999);           // R12 ignored when empty
        do_op(3, 1, 0, 64'h1234);
        do_op(0, 0, 0, '0);
        do_op(1, 1, 0, 64'h0);              // R3 flags out of step with occupancy
        do_op(2, 0, 4, '0);

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom_range(0, 99));
            int tid = int'($urandom_range(0, THREADS - 1));
            logic [DATA_W-1:0] wd = {$urandom, $urandom};
            if (r < 30)      do_op($urandom_range(2, 3), 1, tid, wd);
            else if (r < 60) do_op($urandom_range(2, 3), 0, tid, wd);
            else if (r < 70) do_op(0, 0, tid, wd);
            else if (r < 78) do_op(0, 1, tid, wd);
            else if (r < 95) do_op(1, 0, tid, wd);
            else             do_op(1, 1, tid, wd & 64'h0001_0003);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule